// File: doc/BRIEF.md
# SPI Master with Programmable Data-Out Idle Level

This block is a serial peripheral interface master that moves one word per transfer. A word of 1 to 32 bits goes out on the data-out line and a word of the same length comes in on the data-in line. The configuration selects the clock idle level, which clock edge samples data, the bit order and the active level of chip select. The serial clock comes from the system clock through a programmable divider. Each half period of the serial clock lasts `cfg_div + 1` system clocks.

Its main feature is control of the data-out line whenever no bit cell is being driven. Software can hold the line high or low for the whole time chip select is inactive, and also in the gaps before the first bit and after the last bit while chip select is active. Some peripherals decode that line outside data bits and need this. With no idle level chosen, the line keeps the last bit it sent. A configuration that asks for both levels at once is flagged as an error, and while it is in place no transfer can start.

A transfer word enters through a valid/ready handshake. `tx_ready` is high only when the block is idle and the configuration is legal, and a word is taken on a clock where `tx_valid` and `tx_ready` are both high. The received word leaves as a single-cycle `rx_valid` strobe with no back-pressure. The consumer must capture `rx_data` on that cycle, although `rx_data` then stays unchanged until the next transfer ends. Configuration is a plain write strobe that takes effect only while the block is idle.

Top module: `spi_idle_master`

## Requirements
- R1: After reset: busy is low, tx_ready is high, chip select is inactive (high, because the reset configuration is active-low chip select), the serial clock is low, data-out is low, the word length is 8 and the divider is 0.
- R2: While idle, the serial clock rests at the configured clock-idle level. During a transfer every serial-clock half period lasts cfg_div+1 system clocks.
- R3: With sample-on-leading-edge timing (cfg_cpha=0) and MSB-first order, the first bit is on data-out as chip select asserts, and each later bit changes on a trailing edge. Sending 0xA5 presents 1,0,1,0,0,1,0,1 on successive leading edges.
- R4: With sample-on-trailing-edge timing (cfg_cpha=1), each bit is driven on a leading edge and sampled on the following trailing edge, by the peripheral and by this block alike.
- R5: With cfg_lsb_first=1, bit 0 of the word is sent first. The received word is assembled so that the first received bit lands in bit 0.
- R6: The word length is cfg_len_m1+1 bits, for any value from 1 to 32. Exactly 2*(cfg_len_m1+1) serial-clock edges occur while chip select is active.
- R7: Chip select is driven to cfg_cs_high during a transfer and to its complement otherwise.
- R8: With only idle-high selected, data-out is 1 at all times outside bit cells. This covers the idle state and the lead gap and tail gap while chip select is active.
- R9: With only idle-low selected, data-out is 0 at all times outside bit cells.
- R10: With neither idle level selected, data-out keeps the last bit sent, after the transfer and while idle.
- R11: When both idle levels are selected, cfg_err is high and tx_ready is low. A word presented on tx_valid is refused: busy stays low and chip select stays inactive.
- R12: A configuration write while busy has no effect. A write while idle changes the data-out idle level on the first clock after the write edge.
- R13: rx_valid pulses for exactly one clock, on the clock where chip select goes inactive. rx_data then holds the data-in bits sampled during the transfer.
- R14: A transfer starts only on a clock with tx_valid and tx_ready both high, and tx_ready is low for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cs_high | input | 1 | 1: chip select active high |
| cfg_idle_lo | input | 1 | Request data-out low outside bit cells |
| cfg_idle_hi | input | 1 | Request data-out high outside bit cells |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_div | input | 8 | Half period of the serial clock minus one, in system clocks |
| cfg_err | output | 1 | Stored configuration requests both idle levels |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can accept a transmit word |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe marking the end of a transfer |
| rx_data | output | 32 | Received word, right-aligned |
| busy | output | 1 | Transfer in progress |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
On every cycle the assertions check the idle-state levels: the serial clock at its idle level, chip select inactive, and data-out forced high or low when exactly one idle level is stored. They also check that a stored configuration never changes during a transfer, that an illegal configuration never lets a transfer begin, and that the end-of-transfer strobe lasts one cycle. Other behaviours can only be shown by the bench scenarios, which use a peripheral model that captures data-out on its own sampling edges. These are the bit order for each phase setting and each order, the word lengths at both extremes, the half-period length, the data-out level in the lead and tail gaps while chip select is active, and the last-bit hold with no idle level.

// File: rtl/spi_idle_pkg.sv
package spi_idle_pkg;
  localparam int MAX_BITS = 32;
  localparam int LEN_W    = $clog2(MAX_BITS);
  localparam int DIV_W    = 8;
  localparam int EDGE_W   = LEN_W + 2;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              lsb_first;
    logic              cs_high;
    logic              idle_lo;
    logic              idle_hi;
    logic [LEN_W-1:0]  len_m1;
    logic [DIV_W-1:0]  div;
  } spi_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } spi_state_t;

  localparam spi_cfg_t CFG_RESET = '{
    cpol: 1'b0, cpha: 1'b0, lsb_first: 1'b0, cs_high: 1'b0,
    idle_lo: 1'b0, idle_hi: 1'b0,
    len_m1: LEN_W'(7), div: '0
  };
endpackage

// File: rtl/spi_idle_div.sv
module spi_idle_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_idle_shift.sv
module spi_idle_shift #(
  parameter int MAXB = 32,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXB-1:0] tx_word,
  input  logic [LW-1:0]   len_m1,
  input  logic            lsb_first,
  input  logic            pop,
  input  logic            sample,
  input  logic            din,
  output logic            head,
  output logic [MAXB-1:0] rx_word
);
  localparam int TOP = MAXB - 1;

  logic [MAXB-1:0] tx_sh;
  logic [MAXB-1:0] rx_sh;
  logic [LW-1:0]   align;

  // distance between the word's top bit and the register's top bit
  assign align = LW'(TOP) - len_m1;
  assign head  = lsb_first ? tx_sh[0] : tx_sh[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (load) begin
      tx_sh <= lsb_first ? tx_word : (tx_word << align);
      rx_sh <= '0;
    end else begin
      if (pop)
        tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
      if (sample)
        rx_sh <= lsb_first ? {din, rx_sh[TOP:1]} : {rx_sh[TOP-1:0], din};
    end
  end

  assign rx_word = lsb_first ? (rx_sh >> align) : rx_sh;
endmodule

// File: rtl/spi_idle_master.sv
module spi_idle_master
  import spi_idle_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_lsb_first,
  input  logic                cfg_cs_high,
  input  logic                cfg_idle_lo,
  input  logic                cfg_idle_hi,
  input  logic [LEN_W-1:0]    cfg_len_m1,
  input  logic [DIV_W-1:0]    cfg_div,
  output logic                cfg_err,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                busy,
  output logic                spi_sclk,
  output logic                spi_cs,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  spi_cfg_t          cfg_q;
  spi_state_t        state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] edge_nxt;
  logic [EDGE_W-1:0] edge_last;
  logic              sclk_r;
  logic              drive_en;
  logic              last_bit;
  logic              tick;
  logic              start;
  logic              lead;
  logic              pop;
  logic              sample;
  logic              head;
  logic [MAX_BITS-1:0] rx_word;
  logic              force_hi;
  logic              force_lo;

  assign busy      = (state != ST_IDLE);
  assign cfg_err   = cfg_q.idle_lo & cfg_q.idle_hi;
  assign tx_ready  = (state == ST_IDLE) && !cfg_err;
  assign start     = tx_valid && tx_ready;

  assign edge_nxt  = edge_cnt + 1'b1;
  assign edge_last = EDGE_W'({1'b0, cfg_q.len_m1} + 1'b1) << 1;
  assign lead      = edge_nxt[0];

  // leading edges sample when cpha=0, trailing edges sample when cpha=1
  assign sample = (state == ST_RUN) && tick && (lead ^ cfg_q.cpha);
  // advance to the next bit on the launch edge of every bit but the first
  assign pop    = (state == ST_RUN) && tick &&
                  (cfg_q.cpha ? (lead && edge_nxt != EDGE_W'(1))
                              : (!lead && edge_nxt != edge_last));

  spi_idle_div #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (cfg_q.div),
    .tick  (tick)
  );

  spi_idle_shift #(.MAXB(MAX_BITS), .LW(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .tx_word   (tx_data),
    .len_m1    (cfg_q.len_m1),
    .lsb_first (cfg_q.lsb_first),
    .pop       (pop),
    .sample    (sample),
    .din       (spi_miso),
    .head      (head),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      state    <= ST_IDLE;
      edge_cnt <= '0;
      sclk_r   <= 1'b0;
      drive_en <= 1'b0;
      last_bit <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cfg_we && state == ST_IDLE)
        cfg_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first,
                   cs_high: cfg_cs_high, idle_lo: cfg_idle_lo,
                   idle_hi: cfg_idle_hi, len_m1: cfg_len_m1, div: cfg_div};
      if (drive_en)
        last_bit <= head;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            edge_cnt <= '0;
            sclk_r   <= cfg_q.cpol;
            drive_en <= !cfg_q.cpha;
          end
        end
        ST_RUN: begin
          if (tick) begin
            edge_cnt <= edge_nxt;
            sclk_r   <= ~sclk_r;
            if (cfg_q.cpha && edge_nxt == EDGE_W'(1))
              drive_en <= 1'b1;
            if (!cfg_q.cpha && edge_nxt == edge_last)
              drive_en <= 1'b0;
            if (edge_nxt == edge_last)
              state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state    <= ST_IDLE;
            drive_en <= 1'b0;
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign force_hi = cfg_q.idle_hi & ~cfg_q.idle_lo;
  assign force_lo = cfg_q.idle_lo & ~cfg_q.idle_hi;

  always_comb begin
    if (drive_en)       spi_mosi = head;
    else if (force_hi)  spi_mosi = 1'b1;
    else if (force_lo)  spi_mosi = 1'b0;
    else                spi_mosi = last_bit;
  end

  assign spi_sclk = busy ? sclk_r : cfg_q.cpol;
  assign spi_cs   = busy ? cfg_q.cs_high : ~cfg_q.cs_high;
endmodule

// File: rtl/spi_idle_master_chk.sv
module spi_idle_master_chk
  import spi_idle_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     busy,
  input logic     cfg_err,
  input logic     tx_valid,
  input logic     rx_valid,
  input logic     spi_cs,
  input logic     spi_sclk,
  input logic     spi_mosi,
  input spi_cfg_t cfg_s
);
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && tx_valid && !busy) |=> !busy);                          // R11

  AST_IDLE_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_s.idle_hi && !cfg_s.idle_lo) |-> spi_mosi);          // R8

  AST_IDLE_LO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_s.idle_lo && !cfg_s.idle_hi) |-> !spi_mosi);         // R9

  AST_CS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs != cfg_s.cs_high));                              // R7

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cfg_s.cpol));                               // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);                                           // R13

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_s));                         // R12
endmodule

bind spi_idle_master spi_idle_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .cfg_err  (cfg_err),
  .tx_valid (tx_valid),
  .rx_valid (rx_valid),
  .spi_cs   (spi_cs),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .cfg_s    (cfg_q)
);

// File: tb/spi_idle_master_bench.sv
module spi_idle_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic        cfg_cs_high = 1'b0, cfg_idle_lo = 1'b0, cfg_idle_hi = 1'b0;
  logic [4:0]  cfg_len_m1 = 5'd7;
  logic [7:0]  cfg_div = 8'd0;
  logic        cfg_err;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        busy, spi_sclk, spi_cs, spi_mosi, spi_miso;

  int total = 0;
  int bad = 0;

  // bench copy of the stored configuration
  logic m_cpol = 0, m_cpha = 0, m_lsb = 0, m_csh = 0;
  logic miso_inv = 0;
  logic [31:0] slv_cap;
  int slv_edges;
  int slv_bits;

  always #10 clk = ~clk;

  assign spi_miso = miso_inv ? ~spi_mosi : spi_mosi;

  spi_idle_master u_spi_idle_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cs_high(cfg_cs_high), .cfg_idle_lo(cfg_idle_lo),
    .cfg_idle_hi(cfg_idle_hi), .cfg_len_m1(cfg_len_m1), .cfg_div(cfg_div),
    .cfg_err(cfg_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // peripheral model: captures data-out on its own sampling edges
  always @(spi_sclk) begin
    if (rst_n && spi_cs === m_csh) begin
      slv_edges = slv_edges + 1;
      if ((spi_sclk != m_cpol) ^ m_cpha) begin
        slv_cap  = m_lsb ? {spi_mosi, slv_cap[31:1]} : {slv_cap[30:0], spi_mosi};
        slv_bits = slv_bits + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic do_cfg(input logic cpol, cpha, lsb, csh, ilo, ihi,
                        input int len, input int div);
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_cs_high = csh;
    cfg_idle_lo = ilo; cfg_idle_hi = ihi;
    cfg_len_m1 = 5'(len - 1); cfg_div = 8'(div);
    cfg_we = 1'b1;
    @(posedge clk);
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_csh = csh;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one transfer; exp_lead/exp_tail check data-out in the gaps (-1 skips)
  task automatic xfer(input logic [31:0] w, input int n, input int exp_lead,
                      input int exp_tail, input string req);
    logic [31:0] got;
    logic [31:0] expw;
    bit seen;
    slv_cap = '0; slv_edges = 0; slv_bits = 0;
    @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy && !tx_ready, "R14 busy/ready after accept", {busy, tx_ready}, 2'b10);
    chk(spi_cs == m_csh, "R7 cs active", spi_cs, m_csh);
    if (exp_lead >= 0)
      chk(spi_mosi == exp_lead[0], {req, " lead gap level"}, spi_mosi, exp_lead[0]);
    if (exp_tail >= 0) begin
      wait (slv_edges == 2 * n);
      @(negedge clk);
      chk(spi_cs == m_csh && spi_mosi == exp_tail[0], {req, " tail gap level"},
          {spi_cs, spi_mosi}, {m_csh, exp_tail[0]});
    end
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (rx_valid) seen = 1;
      else @(negedge clk);
    end
    chk(seen, "R13 end strobe seen", seen, 1);
    chk(spi_cs != m_csh, "R13 cs inactive at strobe", spi_cs, !m_csh);
    expw = (miso_inv ? ~w : w) & mask_of(n);
    chk(rx_data == expw, {req, " R13 rx word"}, rx_data, expw);
    got = (m_lsb && n < 32) ? (slv_cap >> (32 - n)) : slv_cap;
    chk((got & mask_of(n)) == (w & mask_of(n)), {req, " peripheral capture"},
        got & mask_of(n), w & mask_of(n));
    chk(slv_edges == 2 * n, "R6 edge count", slv_edges, 2 * n);
    @(negedge clk);
    chk(!rx_valid, "R13 strobe one cycle", rx_valid, 0);
  endtask

  task automatic t_reset;
    chk(!busy && tx_ready, "R1 busy/ready", {busy, tx_ready}, 2'b01);
    chk(spi_cs == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0,
        "R1 line levels", {spi_cs, spi_sclk, spi_mosi}, 3'b100);
    chk(!cfg_err, "R1 no error", cfg_err, 0);
  endtask

  task automatic t_mode0_a5;
    // R3: 0xA5 MSB first, sample on leading edges
    do_cfg(0, 0, 0, 0, 0, 0, 8, 1);
    xfer(32'hA5, 8, 1, -1, "R3");
  endtask

  task automatic t_half_period;
    int cnt;
    logic prev;
    do_cfg(0, 0, 0, 0, 0, 0, 8, 3);
    @(negedge clk);
    tx_data = 32'h55; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    @(spi_sclk);
    prev = spi_sclk;
    cnt = 0;
    for (int i = 0; i < 100 && spi_sclk == prev; i++) begin
      @(posedge clk); #1; cnt++;
    end
    chk(cnt == 4, "R2 half period", cnt, 4);
    wait (!busy);
    @(negedge clk);
    chk(spi_sclk == 1'b0, "R2 clock rests low", spi_sclk, 0);
  endtask

  task automatic t_cpha1_idle_hi;
    do_cfg(1, 1, 0, 0, 0, 1, 8, 2);
    @(negedge clk);
    chk(spi_sclk == 1'b1, "R2 clock rests high", spi_sclk, 1);
    xfer(32'h3C, 8, 1, -1, "R4 R8");
    chk(spi_mosi == 1'b1, "R8 idle high after", spi_mosi, 1);
  endtask

  task automatic t_lsb_inv;
    miso_inv = 1'b1;
    do_cfg(0, 0, 1, 0, 0, 0, 12, 0);
    xfer(32'hB71, 12, 1, -1, "R5");
    miso_inv = 1'b0;
  endtask

  task automatic t_lengths;
    do_cfg(0, 1, 0, 0, 0, 0, 1, 0);
    xfer(32'h1, 1, -1, -1, "R6 len1");
    do_cfg(1, 0, 0, 0, 0, 0, 32, 0);
    xfer(32'hDEAD_BEEF, 32, -1, -1, "R6 len32");
  endtask

  task automatic t_cs_high;
    do_cfg(0, 0, 0, 1, 0, 0, 8, 0);
    @(negedge clk);
    chk(spi_cs == 1'b0, "R7 active-high cs idle", spi_cs, 0);
    xfer(32'h96, 8, -1, -1, "R7");
  endtask

  task automatic t_idle_lo;
    do_cfg(0, 0, 0, 0, 0, 1, 8, 0);
    @(negedge clk);
    cfg_idle_hi = 1'b0; cfg_idle_lo = 1'b1; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(spi_mosi == 1'b0, "R12 level after one clock", spi_mosi, 0);
    xfer(32'hFF, 8, 1, 0, "R9");
    chk(spi_mosi == 1'b0, "R9 idle low after", spi_mosi, 0);
  endtask

  task automatic t_hold_last;
    do_cfg(0, 0, 0, 0, 0, 0, 8, 1);
    xfer(32'h01, 8, 0, 1, "R10");
    repeat (3) @(negedge clk);
    chk(spi_mosi == 1'b1, "R10 holds last bit", spi_mosi, 1);
  endtask

  task automatic t_both_levels;
    do_cfg(0, 0, 0, 0, 1, 1, 8, 0);
    chk(cfg_err && !tx_ready, "R11 error flagged", {cfg_err, tx_ready}, 2'b10);
    @(negedge clk);
    tx_data = 32'h5A; tx_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && spi_cs == 1'b1, "R11 start refused", {busy, spi_cs}, 2'b01);
    tx_valid = 1'b0;
    do_cfg(0, 0, 0, 0, 0, 0, 8, 0);
    chk(!cfg_err && tx_ready, "R11 error clears", {cfg_err, tx_ready}, 2'b01);
  endtask

  task automatic t_cfg_busy;
    bit seen;
    do_cfg(0, 0, 0, 0, 0, 0, 8, 2);
    slv_cap = '0; slv_edges = 0; slv_bits = 0;
    @(negedge clk);
    tx_data = 32'hF0; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    cfg_idle_hi = 1'b1; cfg_lsb_first = 1'b1; cfg_cs_high = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (rx_valid) seen = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    chk(slv_cap[7:0] == 8'hF0, "R12 order unchanged", slv_cap[7:0], 8'hF0);
    chk(spi_mosi == 1'b0 && spi_cs == 1'b1, "R12 write while busy ignored",
        {spi_mosi, spi_cs}, 2'b01);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_a5();
    t_half_period();
    t_cpha1_idle_hi();
    t_lsb_inv();
    t_lengths();
    t_cs_high();
    t_idle_lo();
    t_hold_last();
    t_both_levels();
    t_cfg_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule